// File: doc/BRIEF.md
# Offset-Aligned Encoder Angle Scaler

This block turns one raw sample from an absolute rotary encoder into corrected position data for a motor controller. The sample has two parts: a single-turn count of N bits and a revolution count of M bits. The block adds a signed mechanical offset, given in encoder ticks, to the single-turn count and keeps the result inside one turn. The revolution count is rebuilt so that it steps exactly when the offset-shifted single-turn value wraps. It does not step at the encoder's own raw zero.

The corrected single-turn count is then scaled to a fraction of a turn with a fixed-point reciprocal of the resolution. That fraction becomes an unsigned angle in radians with 24 fractional bits. An electrical angle is also produced: the mechanical turn fraction is multiplied by the pole-pair count and reduced to one turn.

A small state machine runs the sample through four states:
- S_IDLE waits for a sample.
- S_OFFSET applies the offset and the wrap.
- S_SCALE forms the turn fraction.
- S_ELEC forms both angles and publishes every output with a one-cycle strobe.

The transitions are:
- IDLE->OFFSET, taken on an accepted sample.
- OFFSET->SCALE, taken unconditionally.
- SCALE->ELEC, taken unconditionally.
- ELEC->IDLE, taken unconditionally.

Top module: `enc_angle_align`

## Requirements
- R1: While reset is held and after its release, all data outputs read zero and `out_valid_o` is low until the first result is published.
- R2: A sample is accepted on a clock edge where `sample_valid_i` is high and the block is idle. `out_valid_o` rises after exactly the fourth rising edge counted from that edge, and it stays high for exactly one cycle.
- R3: `st_corr_o` equals ((`raw_st_i` mod 2^N) + `offset_i`) mod 2^N. Here N is `st_bits_i` (1..31) and `offset_i` is a two's-complement 32-bit value.
- R4: `mt_corr_o` equals (`raw_mt_i` + floor(((`raw_st_i` mod 2^N) + `offset_i`) / 2^N)) mod 2^M, with M = `mt_bits_i` (0..31). A borrow below zero therefore decrements the revolution count, and a carry past 2^N - 1 increments it, wrapping within M bits.
- R5: When M is 0, `mt_corr_o` is 0, and the single-turn result is the offset-shifted count alone.
- R6: Let F = (`st_corr` * `recip_i`) mod 2^27, where `recip_i` is unsigned with 27 fractional bits. Then `angle_mech_o` = floor(F * 105414357 / 2^27). This is radians with 24 fractional bits, and 105414357 is 2π scaled by 2^24. The value is always below 105414357.
- R7: `angle_el_o` = floor(((F * P) mod 2^27) * 105414357 / 2^27), with P = `pole_pairs_i` (1..255). With P = 1 it equals `angle_mech_o`.
- R8: A zero reciprocal, which is what very fine resolutions produce, makes both angle outputs zero, while the corrected counts remain valid.
- R9: A `sample_valid_i` strobe that arrives while a sample is still in flight is ignored. Between strobes, every data output holds its last published value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid_i | input | 1 | New raw sample present |
| raw_st_i | input | 32 | Raw single-turn count |
| raw_mt_i | input | 32 | Raw revolution count |
| st_bits_i | input | 5 | Single-turn width N |
| mt_bits_i | input | 5 | Revolution width M |
| offset_i | input | 32 | Signed offset in ticks |
| recip_i | input | 27 | Reciprocal of 2^N, 27 fractional bits |
| pole_pairs_i | input | 8 | Pole-pair count |
| st_corr_o | output | 32 | Corrected single-turn count |
| mt_corr_o | output | 32 | Offset-aligned revolution count |
| angle_mech_o | output | 27 | Mechanical angle, rad, 24 fractional bits |
| angle_el_o | output | 27 | Electrical angle, rad, 24 fractional bits |
| out_valid_o | output | 1 | One-cycle strobe of a new result |

## Verification
A wrong wrap decision shows up as a revolution count that is off by one, with the sign of the offset's carry or borrow, in the very strobe that publishes that sample. It can be seen at the ports four edges after acceptance.

A wrong state sequence shows up either as a strobe at the wrong distance from the accepted sample or as a second strobe. It can also show up as data outputs that move between strobes, so the cycles around every pulse are sampled.

A stale captured operand, for example a busy-time strobe that overwrote the inputs, publishes the values of the ignored sample instead of the accepted one.

// File: rtl/enc_align_pkg.sv
package enc_align_pkg;
    localparam int CNT_W  = 32;
    localparam int BITS_W = 5;
    localparam int ANG_W  = 27;
    localparam int PP_W   = 8;
    // 2*pi with 24 fractional bits
    localparam logic [ANG_W-1:0] TWO_PI_Q = 27'd105414357;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_OFFSET = 2'd1,
        S_SCALE  = 2'd2,
        S_ELEC   = 2'd3
    } align_state_e;
endpackage

// File: rtl/enc_offset_wrap.sv
module enc_offset_wrap
    import enc_align_pkg::*;
(
    input  logic [CNT_W-1:0]  raw_st,
    input  logic [CNT_W-1:0]  raw_mt,
    input  logic [CNT_W-1:0]  offset,
    input  logic [BITS_W-1:0] st_bits,
    input  logic [BITS_W-1:0] mt_bits,
    output logic [CNT_W-1:0]  st_corr,
    output logic [CNT_W-1:0]  mt_corr
);
    localparam int SUM_W = CNT_W + 2;

    logic [CNT_W-1:0]        st_mask;
    logic [CNT_W-1:0]        mt_mask;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] turns;

    always_comb begin
        st_mask = (CNT_W'(1) << st_bits) - CNT_W'(1);
        mt_mask = (CNT_W'(1) << mt_bits) - CNT_W'(1);
        sum     = $signed({2'b00, raw_st & st_mask})
                + $signed({{2{offset[CNT_W-1]}}, offset});
        turns   = sum >>> st_bits;
        st_corr = sum[CNT_W-1:0] & st_mask;
        mt_corr = (raw_mt + turns[CNT_W-1:0]) & mt_mask;
    end
endmodule

// File: rtl/enc_turn_to_rad.sv
module enc_turn_to_rad
    import enc_align_pkg::*;
(
    input  logic [ANG_W-1:0] frac,
    input  logic [PP_W-1:0]  mult,
    output logic [ANG_W-1:0] rad
);
    localparam int MP_W = ANG_W + PP_W;
    localparam int RD_W = 2 * ANG_W;

    logic [MP_W-1:0]  scaled_turn;
    logic [RD_W-1:0]  rad_full;

    always_comb begin
        scaled_turn = MP_W'(frac) * MP_W'(mult);
        rad_full    = RD_W'(scaled_turn[ANG_W-1:0]) * RD_W'(TWO_PI_Q);
        rad         = rad_full[RD_W-1:ANG_W];
    end
endmodule

// File: rtl/enc_angle_align.sv
module enc_angle_align
    import enc_align_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid_i,
    input  logic [CNT_W-1:0]    raw_st_i,
    input  logic [CNT_W-1:0]    raw_mt_i,
    input  logic [BITS_W-1:0]   st_bits_i,
    input  logic [BITS_W-1:0]   mt_bits_i,
    input  logic [CNT_W-1:0]    offset_i,
    input  logic [ANG_W-1:0]    recip_i,
    input  logic [PP_W-1:0]     pole_pairs_i,
    output logic [CNT_W-1:0]    st_corr_o,
    output logic [CNT_W-1:0]    mt_corr_o,
    output logic [ANG_W-1:0]    angle_mech_o,
    output logic [ANG_W-1:0]    angle_el_o,
    output logic                out_valid_o
);
    localparam int PROD_W = CNT_W + ANG_W;

    align_state_e state_q, state_d;

    logic [CNT_W-1:0]  raw_st_q, raw_mt_q, offset_q;
    logic [BITS_W-1:0] st_bits_q, mt_bits_q;
    logic [ANG_W-1:0]  recip_q;
    logic [PP_W-1:0]   pp_q;
    logic [CNT_W-1:0]  st_q, mt_q;
    logic [ANG_W-1:0]  frac_q;

    logic [CNT_W-1:0]  st_w, mt_w;
    logic [PROD_W-1:0] prod_w;
    logic [ANG_W-1:0]  mech_w, el_w;

    enc_offset_wrap u_wrap (
        .raw_st  (raw_st_q),
        .raw_mt  (raw_mt_q),
        .offset  (offset_q),
        .st_bits (st_bits_q),
        .mt_bits (mt_bits_q),
        .st_corr (st_w),
        .mt_corr (mt_w)
    );

    assign prod_w = PROD_W'(st_q) * PROD_W'(recip_q);

    enc_turn_to_rad u_mech (
        .frac (frac_q),
        .mult (PP_W'(1)),
        .rad  (mech_w)
    );

    enc_turn_to_rad u_elec (
        .frac (frac_q),
        .mult (pp_q),
        .rad  (el_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (sample_valid_i) state_d = S_OFFSET;
            S_OFFSET: state_d = S_SCALE;
            S_SCALE:  state_d = S_ELEC;
            S_ELEC:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_st_q     <= '0;
            raw_mt_q     <= '0;
            offset_q     <= '0;
            st_bits_q    <= '0;
            mt_bits_q    <= '0;
            recip_q      <= '0;
            pp_q         <= '0;
            st_q         <= '0;
            mt_q         <= '0;
            frac_q       <= '0;
            st_corr_o    <= '0;
            mt_corr_o    <= '0;
            angle_mech_o <= '0;
            angle_el_o   <= '0;
            out_valid_o  <= 1'b0;
        end else begin
            out_valid_o <= 1'b0;
            unique case (state_q)
                S_IDLE: if (sample_valid_i) begin
                    raw_st_q  <= raw_st_i;
                    raw_mt_q  <= raw_mt_i;
                    offset_q  <= offset_i;
                    st_bits_q <= st_bits_i;
                    mt_bits_q <= mt_bits_i;
                    recip_q   <= recip_i;
                    pp_q      <= pole_pairs_i;
                end
                S_OFFSET: begin
                    st_q <= st_w;
                    mt_q <= mt_w;
                end
                S_SCALE: frac_q <= prod_w[ANG_W-1:0];
                S_ELEC: begin
                    st_corr_o    <= st_q;
                    mt_corr_o    <= mt_q;
                    angle_mech_o <= mech_w;
                    angle_el_o   <= el_w;
                    out_valid_o  <= 1'b1;
                end
            endcase
        end
    end

    // R3
    st_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((st_corr_o >> st_bits_q) == '0));
    // R4
    mt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((mt_corr_o >> mt_bits_q) == '0));
    // R6
    mech_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        angle_mech_o < TWO_PI_Q);
    // R7
    el_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        angle_el_o < TWO_PI_Q);
    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> ($stable(st_corr_o) && $stable(mt_corr_o)
                          && $stable(angle_mech_o) && $stable(angle_el_o)));
endmodule

// File: tb/enc_angle_align_tb.sv
module enc_angle_align_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid_i = 1'b0;
    logic [31:0] raw_st_i = '0, raw_mt_i = '0, offset_i = '0;
    logic [4:0]  st_bits_i = 5'd1, mt_bits_i = '0;
    logic [26:0] recip_i = '0;
    logic [7:0]  pole_pairs_i = 8'd1;
    logic [31:0] st_corr_o, mt_corr_o;
    logic [26:0] angle_mech_o, angle_el_o;
    logic        out_valid_o;

    int checks = 0;
    int fails  = 0;
    localparam longint TWO_PI = 64'd105414357;
    longint e_st, e_mt, e_mech, e_el;

    always #10 clk = ~clk;

    enc_angle_align u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid_i(sample_valid_i),
        .raw_st_i(raw_st_i), .raw_mt_i(raw_mt_i), .st_bits_i(st_bits_i),
        .mt_bits_i(mt_bits_i), .offset_i(offset_i), .recip_i(recip_i),
        .pole_pairs_i(pole_pairs_i), .st_corr_o(st_corr_o),
        .mt_corr_o(mt_corr_o), .angle_mech_o(angle_mech_o),
        .angle_el_o(angle_el_o), .out_valid_o(out_valid_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model(input longint rst, input longint rmt, input int n,
                                  input int m, input longint off, input longint rc,
                                  input longint pp);
        longint nmod, mmod, s, turns, frac;
        nmod  = longint'(1) << n;
        mmod  = longint'(1) << m;
        s     = (rst % nmod) + off;
        turns = (s >= 0) ? s / nmod : -((-s + nmod - 1) / nmod);
        e_st  = s - turns * nmod;
        e_mt  = (((rmt + turns) % mmod) + mmod) % mmod;
        frac  = (e_st * rc) % (longint'(1) << 27);
        e_mech = (frac * TWO_PI) >> 27;
        e_el   = (((frac * pp) % (longint'(1) << 27)) * TWO_PI) >> 27;
    endfunction

    task automatic run_one(input logic [31:0] rst, input logic [31:0] rmt,
                           input int n, input int m, input int off,
                           input logic [26:0] rc, input logic [7:0] pp, input string tag);
        @(negedge clk);
        raw_st_i = rst; raw_mt_i = rmt; st_bits_i = 5'(n); mt_bits_i = 5'(m);
        offset_i = off; recip_i = rc; pole_pairs_i = pp; sample_valid_i = 1'b1;
        @(negedge clk);
        sample_valid_i = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check({"R2 early ", tag}, out_valid_o, 0);
        end
        @(negedge clk);
        model(longint'(rst), longint'(rmt), n, m, longint'(off), longint'(rc), longint'(pp));
        check({"R2 ", tag}, out_valid_o, 1);
        check({"R3 ", tag}, st_corr_o, e_st);
        check({"R4 ", tag}, mt_corr_o, e_mt);
        check({"R6 ", tag}, angle_mech_o, e_mech);
        check({"R7 ", tag}, angle_el_o, e_el);
        @(negedge clk);
        check({"R2 pulse ", tag}, out_valid_o, 0);
        check({"R9 hold ", tag}, st_corr_o, e_st);
    endtask

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check("R1 valid", out_valid_o, 0);
        check("R1 st", st_corr_o, 0);
        check("R1 mech", angle_mech_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after", out_valid_o, 0);

        // R4 borrow below zero wraps revolution count
        run_one(32'd5, 32'd0, 12, 8, -20, 27'(1 << 15), 8'd4, "borrow");
        // R4 carry at the top
        run_one(32'd4095, 32'd255, 12, 8, 3, 27'(1 << 15), 8'd3, "carry");
        // R5 single-turn encoder
        run_one(32'd100, 32'hFFFF, 10, 0, -300, 27'(1 << 17), 8'd2, "R5 noturns");
        check("R5 mt zero", mt_corr_o, 0);
        // R7 pole pairs one equals mechanical
        run_one(32'd777, 32'd9, 13, 16, 50, 27'(1 << 14), 8'd1, "pp1");
        check("R7 pp1 match", angle_el_o, angle_mech_o);
        // R8 zero reciprocal
        run_one(32'h0FFF_FFFF, 32'd3, 28, 4, 1, 27'd0, 8'd7, "R8 zero");
        check("R8 mech zero", angle_mech_o, 0);
        check("R8 el zero", angle_el_o, 0);
        // R3 wide 31-bit turn with large negative offset
        run_one(32'h7FFF_FFF0, 32'd1, 31, 31, 32'sh8000_0001, 27'd0, 8'd255, "wide");

        // R9 strobe during busy is ignored
        @(negedge clk);
        raw_st_i = 32'd10; raw_mt_i = 32'd2; st_bits_i = 5'd8; mt_bits_i = 5'd4;
        offset_i = 32'd0; recip_i = 27'(1 << 19); pole_pairs_i = 8'd5; sample_valid_i = 1'b1;
        @(negedge clk);
        raw_st_i = 32'd200; raw_mt_i = 32'd9; offset_i = 32'd40;
        @(negedge clk);
        sample_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        model(10, 2, 8, 4, 0, longint'(1 << 19), 5);
        check("R9 accepted valid", out_valid_o, 1);
        check("R9 first kept", st_corr_o, e_st);
        check("R9 mt kept", mt_corr_o, e_mt);
        repeat (6) begin
            @(negedge clk);
            check("R9 no second pulse", out_valid_o, 0);
        end
        check("R9 outputs hold", angle_el_o, e_el);

        // random mix
        for (int i = 0; i < 60; i++) begin
            int n, m, off;
            logic [31:0] rs, rm;
            n   = 1 + int'($urandom % 27);
            m   = int'($urandom % 32);
            rs  = $urandom & ((32'd1 << n) - 32'd1);
            rm  = $urandom;
            off = int'($urandom % (2 * (1 << n) + 1)) - (1 << n);
            run_one(rs, rm, n, m, off, 27'(1 << (27 - n)), 8'(1 + $urandom % 255), "rand");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule